// File: doc/BRIEF.md
# Programmable Trigger Sequencer

This block decides, sample by sample, what a capture path does with the data it acquires. A table written at run time holds, for every sequencer state, a short list of condition/action clauses. On each valid sample the clauses of the current state are evaluated against an event vector. That vector combines event bits from outside recognizers, two compare results from an internal counter and timer, and the block's own flag bits. The first true clause in index order then fires its actions. These actions can jump to another state, raise the trigger, steer storage, step the counter, control the timer, and set or clear flags.

Software fills the clause table and the two terminal values while the sequencer is idle, then pulses `arm`. The sequencer runs until a clause with the trigger action fires. It then halts with `triggered_o` high and ignores samples until it is armed again. A result strobe `out_vld` follows each evaluated sample by one clock, together with the storage decision and the fired clause.

Top module: `trig_seq`

## Requirements
- R1: Pulsing `arm` sets the state to 0, clears the counter, the timer, the timer-running bit, every flag and `triggered_o`, turns store mode on, and starts the sequencer (`running_o`=1).
- R2: A clause word has: bit 0 enable; bit 1 combine mode (0=AND, 1=OR); bits 9:2 event mask, where event bits 0-3 are `ev_in[3:0]`, bit 4 is the counter hit, bit 5 is the timer hit and bits 6-7 are flags 0-1. An enabled AND clause is true when every masked event is high, so an empty mask is always true. An enabled OR clause is true when any masked event is high, so an empty mask is never true. A disabled clause never fires.
- R3: When several clauses of the current state are true on one sample, only the lowest-numbered one fires. Its index appears on `fire_idx` with `fire_o`=1.
- R4: Bit 10 enables a jump, and bits 14:11 give the target state. The new state is visible on `state_o` one clock after the sample.
- R5: Bit 15 is the trigger action. It gives a one-cycle `trig_o` pulse, sets `triggered_o`, and clears `running_o`. No later sample produces `out_vld` until the next arm.
- R6: Bits 18:16 are the storage action: 0 none, 1 keep this sample, 2 drop this sample, 3 start (this and later samples stored), 4 stop (this and later samples dropped). With no storage action, `store_o` follows the store mode.
- R7: Bits 20:19 are the counter action: 0 none, 1 increment, 2 decrement, 3 clear. The counter wraps modulo 2^51. The new value is seen on `cnt_o`, and by the counter compare, from the next clock on.
- R8: The counter hit event is true while the counter equals the counter terminal value, written with `cfg_kind`=1.
- R9: Bits 22:21 are the timer action: 0 none, 1 start, 2 stop, 3 clear. A running timer counts one per clock while the sequencer runs. It freezes when stopped or after a trigger. The timer hit event is true while the timer is at or above the terminal value written with `cfg_kind`=2.
- R10: Bits 24:23 set flags and bits 26:25 clear flags. Clear wins when both name the same flag.
- R11: Configuration writes (`cfg_kind`=0 clause at `cfg_state`/`cfg_clause`) take effect only while `running_o` is low. Writes made while running are dropped.
- R12: Clocks without `sample_vld` change neither the state nor the flags nor the counter, and give no `out_vld`.
- R13: After reset the sequencer is idle, with state 0, nothing triggered, no flags and a zero counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Restart the sequence from state 0 |
| sample_vld | input | 1 | Current event vector is a sample |
| ev_in | input | 4 | Event bits from outside recognizers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 clause, 1 counter terminal, 2 timer terminal |
| cfg_state | input | 4 | State of the clause written |
| cfg_clause | input | 3 | Clause index written |
| cfg_wdata | input | 51 | Clause word or terminal value |
| out_vld | output | 1 | Result of an evaluated sample |
| store_o | output | 1 | Store the evaluated sample |
| trig_o | output | 1 | Trigger pulse |
| triggered_o | output | 1 | Sequence has triggered |
| running_o | output | 1 | Sequencer is armed and evaluating |
| fire_o | output | 1 | A clause fired on the evaluated sample |
| fire_idx | output | 3 | Index of the fired clause |
| state_o | output | 4 | Current state |
| flags_o | output | 2 | Flag bits |
| cnt_o | output | 51 | Counter value |
| tmr_o | output | 51 | Timer value |

## Verification
The hardest situation to reach is a timer compare firing at an exact clock. The timer counts clocks rather than samples, starts one clock late, and freezes on stop and on trigger. The stimulus therefore starts, stops, clears and restarts the timer with counted idle clocks in between. It checks `tmr_o` at each step, so the clock on which the compare turns true is known before the triggering sample is driven. The counter hit is placed the same way: the sample that completes the count must not see the hit, and the next one must.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

   typedef enum logic [2:0] {
      STO_NONE  = 3'd0,
      STO_KEEP  = 3'd1,
      STO_DROP  = 3'd2,
      STO_START = 3'd3,
      STO_STOP  = 3'd4
   } store_op_e;

   typedef enum logic [1:0] {
      CNT_NONE = 2'd0,
      CNT_INC  = 2'd1,
      CNT_DEC  = 2'd2,
      CNT_CLR  = 2'd3
   } cnt_op_e;

   typedef enum logic [1:0] {
      TMR_NONE  = 2'd0,
      TMR_START = 2'd1,
      TMR_STOP  = 2'd2,
      TMR_CLR   = 2'd3
   } tmr_op_e;

endpackage

// File: rtl/trig_clause_eval.sv
module trig_clause_eval #(
   parameter int EV_W = 8
) (
   input  logic            en,
   input  logic            or_mode,
   input  logic [EV_W-1:0] mask,
   input  logic [EV_W-1:0] events,
   output logic            hit
);
   logic any_sel;
   logic all_sel;

   always_comb begin
      any_sel = |(mask & events);
      all_sel = &(~mask | events);
      hit     = en & (or_mode ? any_sel : all_sel);
   end
endmodule

// File: rtl/trig_prio_pick.sv
module trig_prio_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   logic [N-1:0] below;

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         below[i] = (IW'(i) < idx);
      end
   end

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((req & below) == '0) && req[idx]) else $error("lower clause skipped"); // R3
endmodule

// File: rtl/trig_cnt_tmr.sv
module trig_cnt_tmr
   import trig_seq_pkg::*;
#(
   parameter int W = 51
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         arm,
   input  logic         run,
   input  logic         step,
   input  cnt_op_e      cnt_op,
   input  tmr_op_e      tmr_op,
   input  logic [W-1:0] cnt_term,
   input  logic [W-1:0] tmr_term,
   output logic [W-1:0] cnt,
   output logic [W-1:0] tmr,
   output logic         cnt_hit,
   output logic         tmr_hit
);
   logic tmr_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (arm) begin
         cnt <= '0;
      end else if (step) begin
         case (cnt_op)
            CNT_INC: cnt <= cnt + 1'b1;
            CNT_DEC: cnt <= cnt - 1'b1;
            CNT_CLR: cnt <= '0;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_run <= 1'b0;
         tmr     <= '0;
      end else if (arm) begin
         tmr_run <= 1'b0;
         tmr     <= '0;
      end else begin
         if (step && tmr_op == TMR_START) tmr_run <= 1'b1;
         else if (step && tmr_op == TMR_STOP) tmr_run <= 1'b0;
         if (step && tmr_op == TMR_CLR) tmr <= '0;
         else if (tmr_run && run && tmr != '1) tmr <= tmr + 1'b1;
      end
   end

   assign cnt_hit = (cnt == cnt_term);
   assign tmr_hit = (tmr >= tmr_term);

   AST_CNT_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !arm) |=> $stable(cnt)) else $error("counter moved without a clause"); // R7

   AST_TMR_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_hit && run && !arm && !(step && tmr_op == TMR_CLR)) |=> tmr_hit) else $error("timer hit dropped"); // R9

   AST_TMR_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !arm && !step) |=> $stable(tmr)) else $error("timer moved while halted"); // R9
endmodule

// File: rtl/trig_seq.sv
module trig_seq
   import trig_seq_pkg::*;
#(
   parameter int N_ST  = 16,
   parameter int N_CL  = 8,
   parameter int N_EXT = 4,
   parameter int N_FLG = 2,
   parameter int CNT_W = 51,
   localparam int SW    = $clog2(N_ST),
   localparam int CIW   = $clog2(N_CL),
   localparam int EV_W  = N_EXT + 2 + N_FLG,
   localparam int O_MSK = 2,
   localparam int O_GEN = O_MSK + EV_W,
   localparam int O_GST = O_GEN + 1,
   localparam int O_TRG = O_GST + SW,
   localparam int O_STO = O_TRG + 1,
   localparam int O_CNT = O_STO + 3,
   localparam int O_TMR = O_CNT + 2,
   localparam int O_FS  = O_TMR + 2,
   localparam int O_FC  = O_FS + N_FLG,
   localparam int CL_W  = O_FC + N_FLG,
   localparam int CFG_W = (CL_W > CNT_W) ? CL_W : CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             sample_vld,
   input  logic [N_EXT-1:0] ev_in,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_kind,
   input  logic [SW-1:0]    cfg_state,
   input  logic [CIW-1:0]   cfg_clause,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             out_vld,
   output logic             store_o,
   output logic             trig_o,
   output logic             triggered_o,
   output logic             running_o,
   output logic             fire_o,
   output logic [CIW-1:0]   fire_idx,
   output logic [SW-1:0]    state_o,
   output logic [N_FLG-1:0] flags_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] tmr_o
);
   localparam int TI_W  = SW + CIW;
   localparam int TBL_N = 1 << TI_W;

   if (N_ST < 2 || N_ST > 16 || (1 << SW) != N_ST) begin : g_bad_states
      $error("N_ST must be a power of two from 2 to 16");
   end
   if (N_CL < 2 || N_CL > 16 || (1 << CIW) != N_CL) begin : g_bad_clauses
      $error("N_CL must be a power of two from 2 to 16");
   end
   if (EV_W > 8) begin : g_bad_events
      $error("a clause may combine at most 8 events");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W too small");
   end

   logic [CL_W-1:0]  tbl [TBL_N];
   logic [SW-1:0]    state_q;
   logic             running_q;
   logic             triggered_q;
   logic             store_mode;
   logic [N_FLG-1:0] flags_q;
   logic [CNT_W-1:0] cnt_term;
   logic [CNT_W-1:0] tmr_term;

   logic             cnt_hit;
   logic             tmr_hit;
   logic [EV_W-1:0]  events;
   logic [CL_W-1:0]  row [N_CL];
   logic [N_CL-1:0]  hits;
   logic             any_hit;
   logic [CIW-1:0]   pick;
   logic [CL_W-1:0]  sel;

   logic             go;
   logic             fired;
   logic             a_goto;
   logic [SW-1:0]    a_state;
   logic             a_trig;
   store_op_e        a_sto;
   cnt_op_e          a_cnt;
   tmr_op_e          a_tmr;
   logic [N_FLG-1:0] a_fs;
   logic [N_FLG-1:0] a_fc;
   logic             store_now;
   logic             cfg_open;

   assign events = {flags_q, tmr_hit, cnt_hit, ev_in};

   for (genvar c = 0; c < N_CL; c++) begin : g_clause
      assign row[c] = tbl[{state_q, CIW'(c)}];
      trig_clause_eval #(.EV_W(EV_W)) u_eval (
         .en      (row[c][0]),
         .or_mode (row[c][1]),
         .mask    (row[c][O_MSK +: EV_W]),
         .events  (events),
         .hit     (hits[c])
      );
   end

   trig_prio_pick #(.N(N_CL), .IW(CIW)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (hits),
      .any   (any_hit),
      .idx   (pick)
   );

   assign sel   = row[pick];
   assign go    = sample_vld & running_q & ~arm;
   assign fired = go & any_hit;

   always_comb begin
      a_goto  = fired & sel[O_GEN];
      a_state = sel[O_GST +: SW];
      a_trig  = fired & sel[O_TRG];
      a_sto   = fired ? store_op_e'(sel[O_STO +: 3]) : STO_NONE;
      a_cnt   = fired ? cnt_op_e'(sel[O_CNT +: 2]) : CNT_NONE;
      a_tmr   = fired ? tmr_op_e'(sel[O_TMR +: 2]) : TMR_NONE;
      a_fs    = fired ? sel[O_FS +: N_FLG] : '0;
      a_fc    = fired ? sel[O_FC +: N_FLG] : '0;
      case (a_sto)
         STO_KEEP, STO_START: store_now = 1'b1;
         STO_DROP, STO_STOP:  store_now = 1'b0;
         default:             store_now = store_mode;
      endcase
   end

   trig_cnt_tmr #(.W(CNT_W)) u_ct (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .run      (running_q),
      .step     (fired),
      .cnt_op   (a_cnt),
      .tmr_op   (a_tmr),
      .cnt_term (cnt_term),
      .tmr_term (tmr_term),
      .cnt      (cnt_o),
      .tmr      (tmr_o),
      .cnt_hit  (cnt_hit),
      .tmr_hit  (tmr_hit)
   );

   assign cfg_open = cfg_we & ~running_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TBL_N; i++) tbl[i] <= '0;
         cnt_term <= '1;
         tmr_term <= '1;
      end else if (cfg_open) begin
         case (cfg_kind)
            2'd0:    tbl[{cfg_state, cfg_clause}] <= cfg_wdata[CL_W-1:0];
            2'd1:    cnt_term <= cfg_wdata[CNT_W-1:0];
            2'd2:    tmr_term <= cfg_wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= '0;
         running_q   <= 1'b0;
         triggered_q <= 1'b0;
         store_mode  <= 1'b1;
         flags_q     <= '0;
         out_vld     <= 1'b0;
         store_o     <= 1'b0;
         trig_o      <= 1'b0;
         fire_o      <= 1'b0;
         fire_idx    <= '0;
      end else if (arm) begin
         state_q     <= '0;
         running_q   <= 1'b1;
         triggered_q <= 1'b0;
         store_mode  <= 1'b1;
         flags_q     <= '0;
         out_vld     <= 1'b0;
         store_o     <= 1'b0;
         trig_o      <= 1'b0;
         fire_o      <= 1'b0;
      end else begin
         out_vld <= go;
         store_o <= go & store_now;
         trig_o  <= a_trig;
         fire_o  <= fired;
         if (fired) fire_idx <= pick;
         if (a_goto) state_q <= a_state;
         if (a_trig) begin
            running_q   <= 1'b0;
            triggered_q <= 1'b1;
         end
         if (a_sto == STO_START) store_mode <= 1'b1;
         else if (a_sto == STO_STOP) store_mode <= 1'b0;
         flags_q <= (flags_q | a_fs) & ~a_fc;
      end
   end

   assign triggered_o = triggered_q;
   assign running_o   = running_q;
   assign state_o     = state_q;
   assign flags_o     = flags_q;

   AST_HALT_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered_q && !arm) |=> !out_vld) else $error("sample evaluated after trigger"); // R5

   AST_TRIG_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> (triggered_o && !running_o)) else $error("trigger without halt"); // R5

   AST_TERMS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && !arm) |=> ($stable(cnt_term) && $stable(tmr_term))) else $error("terminal changed while running"); // R11

   AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_vld && !arm) |=> ($stable(state_q) && $stable(flags_q) && !out_vld)) else $error("state moved without sample"); // R12

   AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (state_q == '0 && running_q && !triggered_q && flags_q == '0 && cnt_o == '0)) else $error("arm left state behind"); // R1
endmodule

// File: tb/trig_seq_test.sv
module trig_seq_test;
   localparam int CLK_NS = 10;
   localparam int CFG_W  = 51;

   typedef struct {
      logic       fire;
      logic [2:0] idx;
      logic       store;
      logic       trig;
      logic [3:0] st;
      logic [1:0] flg;
      int         req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic        sample_vld = 1'b0;
   logic [3:0]  ev_in = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_kind = '0;
   logic [3:0]  cfg_state = '0;
   logic [2:0]  cfg_clause = '0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic        out_vld, store_o, trig_o, triggered_o, running_o, fire_o;
   logic [2:0]  fire_idx;
   logic [3:0]  state_o;
   logic [1:0]  flags_o;
   logic [50:0] cnt_o, tmr_o;

   int checks = 0;
   int errors = 0;
   exp_t q[$];

   always #(CLK_NS/2) clk = ~clk;

   trig_seq uut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .sample_vld(sample_vld), .ev_in(ev_in),
      .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_state(cfg_state), .cfg_clause(cfg_clause),
      .cfg_wdata(cfg_wdata), .out_vld(out_vld), .store_o(store_o), .trig_o(trig_o),
      .triggered_o(triggered_o), .running_o(running_o), .fire_o(fire_o), .fire_idx(fire_idx),
      .state_o(state_o), .flags_o(flags_o), .cnt_o(cnt_o), .tmr_o(tmr_o)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [CFG_W-1:0] mk(input bit en, input bit orm, input logic [7:0] msk,
      input bit gen, input logic [3:0] gst, input bit trg, input logic [2:0] sto,
      input logic [1:0] cop, input logic [1:0] top, input logic [1:0] fs, input logic [1:0] fc);
      logic [CFG_W-1:0] w;
      w = '0;
      w[0] = en; w[1] = orm; w[9:2] = msk; w[10] = gen; w[14:11] = gst; w[15] = trg;
      w[18:16] = sto; w[20:19] = cop; w[22:21] = top; w[24:23] = fs; w[26:25] = fc;
      return w;
   endfunction

   task automatic wr(input logic [1:0] kind, input int st, input int cl, input logic [CFG_W-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = kind; cfg_state = 4'(st); cfg_clause = 3'(cl); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_tbl();
      for (int s = 0; s < 4; s++)
         for (int c = 0; c < 8; c++) wr(2'd0, s, c, '0);
   endtask

   task automatic do_arm();
      @(negedge clk);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   // driver: pushes the expected result, then presents one sample
   task automatic smp(input logic [3:0] ev, input logic fire, input int idx, input logic store,
                      input logic trig, input int st, input logic [1:0] flg, input int req);
      exp_t e;
      e.fire = fire; e.idx = 3'(idx); e.store = store; e.trig = trig;
      e.st = 4'(st); e.flg = flg; e.req = req;
      @(negedge clk);
      q.push_back(e);
      sample_vld = 1'b1; ev_in = ev;
      @(negedge clk);
      sample_vld = 1'b0; ev_in = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // monitor: pops and compares as results appear
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R5 unexpected result actual out_vld 1 expected 0");
         end else begin
            exp_t e;
            string t;
            e = q.pop_front();
            t = $sformatf("R%0d", e.req);
            check({t, " fire"},  64'(fire_o),  64'(e.fire));
            if (e.fire) check({t, " idx"}, 64'(fire_idx), 64'(e.idx));
            check({t, " store"}, 64'(store_o), 64'(e.store));
            check({t, " trig"},  64'(trig_o),  64'(e.trig));
            check({t, " state"}, 64'(state_o), 64'(e.st));
            check({t, " flags"}, 64'(flags_o), 64'(e.flg));
         end
      end
   end

   initial begin
      #(CLK_NS * 100000);
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R13 reset state
      check("R13 running", 64'(running_o), 0);
      check("R13 triggered", 64'(triggered_o), 0);
      check("R13 state", 64'(state_o), 0);
      check("R13 cnt", 64'(cnt_o), 0);
      check("R13 out_vld", 64'(out_vld), 0);

      // ---- state walk: R2 R3 R4 R6 R5 R12
      wr(0, 0, 0, mk(1,0,8'h03, 1,2, 0,0,0,0, 0,0));
      wr(0, 0, 1, mk(1,1,8'h06, 1,1, 0,0,0,0, 2'b01,0));
      wr(0, 0, 2, mk(0,0,8'h00, 1,3, 0,0,0,0, 0,0));
      wr(0, 1, 0, mk(1,0,8'h48, 1,3, 0,2,0,0, 0,2'b01));
      wr(0, 1, 3, mk(1,0,8'h00, 0,0, 0,0,0,0, 0,0));
      wr(0, 2, 0, mk(1,1,8'h00, 1,0, 0,0,0,0, 0,0));
      wr(0, 2, 1, mk(1,0,8'h01, 0,0, 1,0,0,0, 0,0));
      wr(0, 2, 2, mk(1,0,8'h04, 0,0, 0,3,0,0, 0,0));
      wr(0, 3, 0, mk(1,0,8'h00, 1,0, 0,4,0,0, 0,0));
      do_arm();
      check("R1 running", 64'(running_o), 1);
      smp(4'b0000, 0,0, 1,0, 0,2'b00, 2);   // R2 disabled clause and unmet AND/OR
      smp(4'b0100, 1,1, 1,0, 1,2'b01, 4);   // R4 OR clause jumps, sets flag (R10)
      // R12 events without sample_vld change nothing
      @(negedge clk); ev_in = 4'b1000; idle(3); ev_in = '0;
      check("R12 state", 64'(state_o), 1);
      check("R12 flags", 64'(flags_o), 1);
      smp(4'b0000, 1,3, 1,0, 1,2'b01, 2);   // R2 empty AND mask always true
      smp(4'b1000, 1,0, 0,0, 3,2'b00, 6);   // R6 drop, flag event, flag clear
      smp(4'b0000, 1,0, 0,0, 0,2'b00, 6);   // R6 stop
      smp(4'b0011, 1,0, 0,0, 2,2'b00, 3);   // R3 clauses 0 and 1 true, 0 wins
      smp(4'b0000, 0,0, 0,0, 2,2'b00, 2);   // R2 empty OR mask never true
      smp(4'b0100, 1,2, 1,0, 2,2'b00, 6);   // R6 start
      smp(4'b0001, 1,1, 1,1, 2,2'b00, 5);   // R5 trigger
      check("R5 triggered", 64'(triggered_o), 1);
      check("R5 running", 64'(running_o), 0);
      smp_none(4'b0001);                    // R5 ignored after trigger
      check("R5 state held", 64'(state_o), 2);
      check("R5 queue", 64'(q.size()), 0);

      // ---- counter: R7 R8
      clear_tbl();
      wr(1, 0, 0, 51'd3);
      wr(0, 0, 0, mk(1,0,8'h10, 0,0, 1,0,0,0, 0,0));
      wr(0, 0, 1, mk(1,0,8'h01, 0,0, 0,0,1,0, 0,0));
      wr(0, 0, 2, mk(1,0,8'h02, 0,0, 0,0,2,0, 0,0));
      wr(0, 0, 3, mk(1,0,8'h04, 0,0, 0,0,3,0, 0,0));
      do_arm();
      check("R1 state after arm", 64'(state_o), 0);
      check("R1 triggered cleared", 64'(triggered_o), 0);
      smp(4'b0001, 1,1, 1,0, 0,0, 7);
      smp(4'b0001, 1,1, 1,0, 0,0, 7);
      check("R7 inc", 64'(cnt_o), 2);
      smp(4'b0010, 1,2, 1,0, 0,0, 7);
      check("R7 dec", 64'(cnt_o), 1);
      smp(4'b0100, 1,3, 1,0, 0,0, 7);
      check("R7 clr", 64'(cnt_o), 0);
      smp(4'b0010, 1,2, 1,0, 0,0, 7);
      check("R7 wrap", 64'(cnt_o), 64'h7_FFFF_FFFF_FFFF);
      smp(4'b0100, 1,3, 1,0, 0,0, 7);
      smp(4'b0001, 1,1, 1,0, 0,0, 7);
      smp(4'b0001, 1,1, 1,0, 0,0, 7);
      smp(4'b0001, 1,1, 1,0, 0,0, 8);       // R8 hit not seen on the reaching sample
      check("R7 count 3", 64'(cnt_o), 3);
      smp(4'b0010, 1,0, 1,1, 0,0, 8);       // R8 hit beats the decrement
      check("R8 cnt held", 64'(cnt_o), 3);

      // ---- timer: R9
      clear_tbl();
      wr(2, 0, 0, 51'd5);
      wr(0, 0, 0, mk(1,0,8'h20, 0,0, 1,0,0,0, 0,0));
      wr(0, 0, 1, mk(1,0,8'h01, 0,0, 0,0,0,1, 0,0));
      wr(0, 0, 2, mk(1,0,8'h02, 0,0, 0,0,0,2, 0,0));
      wr(0, 0, 3, mk(1,0,8'h04, 0,0, 0,0,0,3, 0,0));
      do_arm();
      check("R1 tmr", 64'(tmr_o), 0);
      smp(4'b0001, 1,1, 1,0, 0,0, 9);
      check("R9 start latency", 64'(tmr_o), 0);
      idle(2);
      check("R9 counting", 64'(tmr_o), 2);
      smp(4'b0010, 1,2, 1,0, 0,0, 9);
      idle(3);
      check("R9 stopped", 64'(tmr_o), 4);
      smp(4'b0100, 1,3, 1,0, 0,0, 9);
      check("R9 clear", 64'(tmr_o), 0);
      smp(4'b0001, 1,1, 1,0, 0,0, 9);
      idle(5);
      check("R9 before hit", 64'(tmr_o), 5);
      smp(4'b0000, 1,0, 1,1, 0,0, 9);       // R9 hit at or above terminal
      idle(2);
      check("R9 frozen after trigger", 64'(tmr_o), 7);

      // ---- flags: R10, then locked config R11
      clear_tbl();
      wr(0, 0, 0, mk(1,0,8'h01, 0,0, 0,0,0,0, 2'b11,0));
      wr(0, 0, 1, mk(1,0,8'h02, 0,0, 0,4,0,0, 2'b10,2'b10));
      do_arm();
      smp(4'b0001, 1,0, 1,0, 0,2'b11, 10);
      smp(4'b0010, 1,1, 0,0, 0,2'b01, 10);  // R10 clear wins over set
      wr(0, 0, 2, mk(1,0,8'h00, 0,0, 1,0,0,0, 0,0)); // R11 dropped while running
      do_arm();
      check("R1 flags cleared", 64'(flags_o), 0);
      smp(4'b0000, 0,0, 1,0, 0,0, 11);      // R11 old table; R1 store mode back on
      check("R11 still running", 64'(running_o), 1);

      idle(3);
      check("R5 scoreboard drained", 64'(q.size()), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic smp_none(input logic [3:0] ev);
      @(negedge clk);
      sample_vld = 1'b1; ev_in = ev;
      @(negedge clk);
      sample_vld = 1'b0; ev_in = '0;
      idle(1);
   endtask
endmodule